// File: doc/BRIEF.md
# Parallel memory programming sequencer

This block sits on the host side of a byte-wide parallel programming link to a target microcontroller. It handles two operations. The first writes one page of the target's data EEPROM. The second reads one 16-bit word from the target's program Flash. A request arrives on a valid/ready command port with an operation bit and a start address. For a page write, the data bytes then arrive one at a time on a separate valid/ready byte port. The sequencer turns each request into the pin-level sequence the target expects. It drives the data bus, the two-bit load-mode code, the byte-select line, the load clock, the buffer-latch strobe and the active-low write and read-enable strobes. It then watches the target's ready line.

Each load follows the same pattern. The sequencer drives the bus and the mode code, waits a setup time, and then gives one positive load-clock pulse. A page write runs these steps in order:

1. Load the command byte.
2. Load the address high byte.
3. For every byte in the page: load the address low byte, load the data byte, then pulse the latch strobe. The low address goes up by one each time.
4. Commit the page with a low write pulse while byte-select is 0.
5. Wait for the target's ready line to return high.

A Flash read loads the command and both address bytes. It then lowers read-enable with byte-select at 0 and captures the low byte. It raises byte-select to capture the high byte, restores read-enable, and presents the word for one cycle.

**States and transitions:**
- `S_IDLE` goes to `S_LD_SETUP` when a command is accepted.
- `S_LD_SETUP` goes to `S_LD_CLK` when the setup time expires.
- `S_LD_CLK`, at the end of its pulse, goes to one of:
  - the next `S_LD_SETUP` after the command step or the high-address step;
  - `S_DATA_WAIT` after the low-address step of a write;
  - `S_RD_LO` after the low-address step of a read;
  - `S_LATCH` after the data step.
- `S_DATA_WAIT` goes to `S_LD_SETUP` when a byte is accepted.
- `S_LATCH` goes back to `S_LD_SETUP` for the next low-address step, or to `S_COMMIT_SETUP` after the last byte of the page.
- The commit path runs `S_COMMIT_SETUP`, then `S_WR_PULSE`, then `S_BUSY_GAP`, then `S_BUSY_WAIT`.
- `S_BUSY_WAIT` returns to `S_IDLE` when ready is seen high, or when the timeout expires.
- The read path runs `S_RD_LO`, then `S_RD_HI`, then `S_RD_DONE`, then `S_IDLE`.

Top module: `pprog_seq`

## Requirements
- R1: Reset state:
  - `cmd_ready` is 1.
  - `tgt_rd_n` and `tgt_wr_n` are 1.
  - `tgt_clk`, `tgt_latch`, `tgt_dq_oe`, `rd_valid` and `err_timeout` are 0.
- R2: Every load commits with one positive `tgt_clk` pulse, while the mode code, byte-select and bus value stay stable. A page write first loads the command byte 0x11 with mode 2'b10. It then loads the address high byte with mode 2'b00 and byte-select 1.
- R3: For each page byte, a write runs three steps in order:
  - load the address low byte (mode 2'b00, byte-select 0);
  - load the data byte (mode 2'b01);
  - pulse `tgt_latch` high.

  These three steps run PAGE_BYTES times. The low address starts at `cmd_addr_lo` and goes up by 1 modulo 256 each time.
- R4: After the last latch, the page is committed with byte-select 0 and a low pulse on `tgt_wr_n`. The block returns to `cmd_ready` only once `tgt_ready` is seen high. No load clock is issued while the target is busy.
- R5: A Flash read proceeds as follows:
  - It loads the command byte 0x02 with mode 2'b10, then the address high byte, then the address low byte.
  - It drives `tgt_rd_n` low with byte-select 0 and captures the low byte.
  - It sets byte-select to 1 and captures the high byte.
  - It returns `tgt_rd_n` to 1.
  - It then pulses `rd_valid` for exactly one cycle, with `rd_word` = {high, low}.
- R6: `tgt_dq_oe` is high only during load steps and never while `tgt_rd_n` is low.
- R7: If `tgt_ready` stays low for BUSY_LIMIT cycles after a commit, `err_timeout` is set and the block returns to idle. The flag clears when the next command is accepted.
- R8: Handshakes:
  - A command is taken only on a cycle with `cmd_valid` and `cmd_ready` both high.
  - A data byte is taken only while `wr_data_ready` is high.
  - `wr_data_ready` stays low throughout a Flash read.
- R9: Each `tgt_clk` pulse and each `tgt_latch` pulse stays high for exactly PULSE_CLKS cycles. Each `tgt_wr_n` pulse stays low for exactly PULSE_CLKS cycles.
- R10: At most one of these is active in any cycle: `tgt_clk` high, `tgt_latch` high, `tgt_wr_n` low, `tgt_rd_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Operation request valid |
| cmd_ready | output | 1 | Sequencer idle, request can be taken |
| cmd_op | input | 1 | 0 = EEPROM page write, 1 = Flash word read |
| cmd_addr_hi | input | 8 | Address high byte |
| cmd_addr_lo | input | 8 | Address low byte (start address for a page) |
| wr_data_valid | input | 1 | Page data byte valid |
| wr_data | input | 8 | Page data byte |
| wr_data_ready | output | 1 | Sequencer waiting for the next page byte |
| rd_valid | output | 1 | One-cycle strobe, read word available |
| rd_word | output | 16 | Word read from Flash |
| err_timeout | output | 1 | Target stayed busy too long |
| tgt_dq_o | output | 8 | Value for the target data bus |
| tgt_dq_oe | output | 1 | Drive enable for the target data bus |
| tgt_dq_i | input | 8 | Value read from the target data bus |
| tgt_mode | output | 2 | Load-mode code: 10 command, 00 address, 01 data |
| tgt_bytesel | output | 1 | Byte select: high/low address or read byte |
| tgt_clk | output | 1 | Load clock, one positive pulse per load |
| tgt_latch | output | 1 | Page-buffer latch strobe, active high |
| tgt_wr_n | output | 1 | Write strobe, active low |
| tgt_rd_n | output | 1 | Read enable, active low |
| tgt_ready | input | 1 | Target ready (low while busy) |

## Verification
The bench uses PAGE_BYTES=4, PULSE_CLKS=5, SETUP_CLKS=3 and BUSY_LIMIT=200. The pulse and setup times differ, so a swapped timer length shows up as a wrong pulse width. A four-byte page lets a start address of 0xFE exercise the low-address wrap. The short busy limit lets a target model that never raises ready reach the timeout path in a few hundred cycles. The behavioural target records every load and latch, and it holds ready low for 30 cycles after each commit. This means the wait-for-ready path and the no-load-while-busy rule are both exercised by back-to-back page writes.

// File: rtl/pprog_pkg.sv
package pprog_pkg;

    localparam logic [7:0] CMD_EE_PAGE_WRITE = 8'h11;
    localparam logic [7:0] CMD_FLASH_READ    = 8'h02;

    localparam logic [1:0] MODE_ADDR = 2'b00;
    localparam logic [1:0] MODE_DATA = 2'b01;
    localparam logic [1:0] MODE_CMD  = 2'b10;

    typedef enum logic [1:0] {
        STEP_CMD,
        STEP_AHI,
        STEP_ALO,
        STEP_DATA
    } load_step_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LD_SETUP,
        S_LD_CLK,
        S_DATA_WAIT,
        S_LATCH,
        S_COMMIT_SETUP,
        S_WR_PULSE,
        S_BUSY_GAP,
        S_BUSY_WAIT,
        S_RD_LO,
        S_RD_HI,
        S_RD_DONE
    } seq_state_t;

endpackage

// File: rtl/pprog_span_timer.sv
// Counts cycles spent in the current state; done marks the last cycle of a span.
module pprog_span_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] len,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt >= (len - W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/pprog_busy_guard.sv
// Counts consecutive cycles of waiting on the target; expires after LIMIT cycles.
module pprog_busy_guard #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int GW = $clog2(LIMIT + 1);

    logic [GW-1:0] cnt;

    assign expired = active && (cnt == GW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + GW'(1);
        end
    end
endmodule

// File: rtl/pprog_seq.sv
module pprog_seq
    import pprog_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int PULSE_CLKS = 4,
    parameter int SETUP_CLKS = 4,
    parameter int BUSY_LIMIT = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic        cmd_op,
    input  logic [7:0]  cmd_addr_hi,
    input  logic [7:0]  cmd_addr_lo,
    input  logic        wr_data_valid,
    input  logic [7:0]  wr_data,
    output logic        wr_data_ready,
    output logic        rd_valid,
    output logic [15:0] rd_word,
    output logic        err_timeout,
    output logic [7:0]  tgt_dq_o,
    output logic        tgt_dq_oe,
    input  logic [7:0]  tgt_dq_i,
    output logic [1:0]  tgt_mode,
    output logic        tgt_bytesel,
    output logic        tgt_clk,
    output logic        tgt_latch,
    output logic        tgt_wr_n,
    output logic        tgt_rd_n,
    input  logic        tgt_ready
);
    localparam int SPAN_MAX = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
    localparam int TW       = $clog2(SPAN_MAX + 1);
    localparam int BCW      = $clog2(PAGE_BYTES + 1);

    seq_state_t state_q, state_d;
    load_step_t step_q, step_d;

    logic           op_rd_q;
    logic [7:0]     ahi_q, alo_q, data_q, rd_lo_q;
    logic [15:0]    rd_word_q;
    logic [BCW-1:0] cnt_q;
    logic           err_q;

    logic [TW-1:0]  span_len;
    logic           span_done;
    logic           span_clr;
    logic           busy_expired;
    logic           last_byte;

    assign last_byte = (cnt_q == BCW'(PAGE_BYTES - 1));

    // Length of the timed span belonging to the current state
    always_comb begin
        unique case (state_q)
            S_LD_SETUP, S_COMMIT_SETUP, S_BUSY_GAP,
            S_RD_LO, S_RD_HI:                 span_len = TW'(SETUP_CLKS);
            S_LD_CLK, S_LATCH, S_WR_PULSE:    span_len = TW'(PULSE_CLKS);
            default:                          span_len = TW'(1);
        endcase
    end

    pprog_span_timer #(.W(TW)) u_span (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (span_clr),
        .len   (span_len),
        .done  (span_done)
    );

    pprog_busy_guard #(.LIMIT(BUSY_LIMIT)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == S_BUSY_WAIT),
        .expired (busy_expired)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    state_d = S_LD_SETUP;
                    step_d  = STEP_CMD;
                end
            end
            S_LD_SETUP: begin
                if (span_done) state_d = S_LD_CLK;
            end
            S_LD_CLK: begin
                if (span_done) begin
                    unique case (step_q)
                        STEP_CMD: begin
                            state_d = S_LD_SETUP;
                            step_d  = STEP_AHI;
                        end
                        STEP_AHI: begin
                            state_d = S_LD_SETUP;
                            step_d  = STEP_ALO;
                        end
                        STEP_ALO:  state_d = op_rd_q ? S_RD_LO : S_DATA_WAIT;
                        STEP_DATA: state_d = S_LATCH;
                        default:   state_d = S_IDLE;
                    endcase
                end
            end
            S_DATA_WAIT: begin
                if (wr_data_valid) begin
                    state_d = S_LD_SETUP;
                    step_d  = STEP_DATA;
                end
            end
            S_LATCH: begin
                if (span_done) begin
                    if (last_byte) begin
                        state_d = S_COMMIT_SETUP;
                    end else begin
                        state_d = S_LD_SETUP;
                        step_d  = STEP_ALO;
                    end
                end
            end
            S_COMMIT_SETUP: if (span_done) state_d = S_WR_PULSE;
            S_WR_PULSE:     if (span_done) state_d = S_BUSY_GAP;
            S_BUSY_GAP:     if (span_done) state_d = S_BUSY_WAIT;
            S_BUSY_WAIT: begin
                if (tgt_ready || busy_expired) state_d = S_IDLE;
            end
            S_RD_LO:   if (span_done) state_d = S_RD_HI;
            S_RD_HI:   if (span_done) state_d = S_RD_DONE;
            S_RD_DONE: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    assign span_clr = (state_d != state_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= STEP_CMD;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
        end
    end

    // Operation registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_rd_q   <= 1'b0;
            ahi_q     <= '0;
            alo_q     <= '0;
            data_q    <= '0;
            rd_lo_q   <= '0;
            rd_word_q <= '0;
            cnt_q     <= '0;
            err_q     <= 1'b0;
        end else begin
            if (state_q == S_IDLE && cmd_valid) begin
                op_rd_q <= cmd_op;
                ahi_q   <= cmd_addr_hi;
                alo_q   <= cmd_addr_lo;
                cnt_q   <= '0;
                err_q   <= 1'b0;
            end
            if (state_q == S_DATA_WAIT && wr_data_valid) begin
                data_q <= wr_data;
            end
            if (state_q == S_LATCH && span_done && !last_byte) begin
                cnt_q <= cnt_q + BCW'(1);
                alo_q <= alo_q + 8'd1;
            end
            if (state_q == S_BUSY_WAIT && !tgt_ready && busy_expired) begin
                err_q <= 1'b1;
            end
            if (state_q == S_RD_LO && span_done) begin
                rd_lo_q <= tgt_dq_i;
            end
            if (state_q == S_RD_HI && span_done) begin
                rd_word_q <= {tgt_dq_i, rd_lo_q};
            end
        end
    end

    // Output decode (Moore)
    always_comb begin
        tgt_dq_o    = 8'h00;
        tgt_dq_oe   = 1'b0;
        tgt_mode    = MODE_ADDR;
        tgt_bytesel = 1'b0;
        tgt_clk     = 1'b0;
        tgt_latch   = 1'b0;
        tgt_wr_n    = 1'b1;
        tgt_rd_n    = 1'b1;
        unique case (state_q)
            S_LD_SETUP, S_LD_CLK: begin
                tgt_dq_oe = 1'b1;
                tgt_clk   = (state_q == S_LD_CLK);
                unique case (step_q)
                    STEP_CMD: begin
                        tgt_mode = MODE_CMD;
                        tgt_dq_o = op_rd_q ? CMD_FLASH_READ : CMD_EE_PAGE_WRITE;
                    end
                    STEP_AHI: begin
                        tgt_mode    = MODE_ADDR;
                        tgt_bytesel = 1'b1;
                        tgt_dq_o    = ahi_q;
                    end
                    STEP_ALO: begin
                        tgt_mode = MODE_ADDR;
                        tgt_dq_o = alo_q;
                    end
                    STEP_DATA: begin
                        tgt_mode = MODE_DATA;
                        tgt_dq_o = data_q;
                    end
                    default: tgt_dq_o = 8'h00;
                endcase
            end
            S_LATCH:    tgt_latch = 1'b1;
            S_WR_PULSE: tgt_wr_n  = 1'b0;
            S_RD_LO:    tgt_rd_n  = 1'b0;
            S_RD_HI: begin
                tgt_rd_n    = 1'b0;
                tgt_bytesel = 1'b1;
            end
            default: tgt_rd_n = 1'b1;
        endcase
    end

    assign cmd_ready     = (state_q == S_IDLE);
    assign wr_data_ready = (state_q == S_DATA_WAIT);
    assign rd_valid      = (state_q == S_RD_DONE);
    assign rd_word       = rd_word_q;
    assign err_timeout   = err_q;

endmodule

// File: rtl/pprog_seq_chk.sv
module pprog_seq_chk #(
    parameter int PULSE_CLKS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       rd_valid,
    input logic       err_timeout,
    input logic [7:0] tgt_dq_o,
    input logic       tgt_dq_oe,
    input logic [1:0] tgt_mode,
    input logic       tgt_bytesel,
    input logic       tgt_clk,
    input logic       tgt_latch,
    input logic       tgt_wr_n,
    input logic       tgt_rd_n
);
    logic [15:0] clk_run, latch_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_run   <= '0;
            latch_run <= '0;
        end else begin
            clk_run   <= tgt_clk   ? ((clk_run   == 16'hFFFF) ? clk_run   : clk_run   + 16'd1) : 16'd0;
            latch_run <= tgt_latch ? ((latch_run == 16'hFFFF) ? latch_run : latch_run + 16'd1) : 16'd0;
        end
    end

    p_bus_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rd_n |-> !tgt_dq_oe);

    p_clk_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_clk |-> tgt_dq_oe);

    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tgt_clk, tgt_latch, !tgt_wr_n, !tgt_rd_n}));

    p_load_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_clk && $past(tgt_clk)) |-> ($stable(tgt_dq_o) && $stable(tgt_mode) && $stable(tgt_bytesel)));

    p_commit_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_wr_n |-> !tgt_bytesel);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (tgt_rd_n && tgt_wr_n && !tgt_dq_oe && !tgt_latch && !tgt_clk));

    p_rdv_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_rdv_oe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> tgt_rd_n);

    p_clk_width_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_clk |-> (clk_run < 16'(PULSE_CLKS)));

    p_clk_width_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_clk) |-> (clk_run == 16'(PULSE_CLKS)));

    p_latch_width_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_latch) |-> (latch_run == 16'(PULSE_CLKS)));

    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> cmd_ready);

endmodule

bind pprog_seq pprog_seq_chk #(.PULSE_CLKS(PULSE_CLKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .rd_valid    (rd_valid),
    .err_timeout (err_timeout),
    .tgt_dq_o    (tgt_dq_o),
    .tgt_dq_oe   (tgt_dq_oe),
    .tgt_mode    (tgt_mode),
    .tgt_bytesel (tgt_bytesel),
    .tgt_clk     (tgt_clk),
    .tgt_latch   (tgt_latch),
    .tgt_wr_n    (tgt_wr_n),
    .tgt_rd_n    (tgt_rd_n)
);

// File: tb/tb_pprog_seq.sv
`timescale 1ns/1ps
module tb_pprog_seq;
    localparam int PAGE   = 4;
    localparam int PULSE  = 5;
    localparam int SETUP  = 3;
    localparam int LIMIT  = 200;
    localparam int BUSY_T = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        cmd_valid = 1'b0, cmd_op = 1'b0;
    logic [7:0]  cmd_addr_hi = '0, cmd_addr_lo = '0;
    logic        wr_data_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        cmd_ready, wr_data_ready, rd_valid, err_timeout;
    logic [15:0] rd_word;
    logic [7:0]  tgt_dq_o, tgt_dq_i;
    logic        tgt_dq_oe, tgt_bytesel, tgt_clk, tgt_latch, tgt_wr_n, tgt_rd_n, tgt_ready;
    logic [1:0]  tgt_mode;

    pprog_seq #(.PAGE_BYTES(PAGE), .PULSE_CLKS(PULSE), .SETUP_CLKS(SETUP), .BUSY_LIMIT(LIMIT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr_hi(cmd_addr_hi), .cmd_addr_lo(cmd_addr_lo), .wr_data_valid(wr_data_valid),
        .wr_data(wr_data), .wr_data_ready(wr_data_ready), .rd_valid(rd_valid), .rd_word(rd_word),
        .err_timeout(err_timeout), .tgt_dq_o(tgt_dq_o), .tgt_dq_oe(tgt_dq_oe), .tgt_dq_i(tgt_dq_i),
        .tgt_mode(tgt_mode), .tgt_bytesel(tgt_bytesel), .tgt_clk(tgt_clk), .tgt_latch(tgt_latch),
        .tgt_wr_n(tgt_wr_n), .tgt_rd_n(tgt_rd_n), .tgt_ready(tgt_ready)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] flash_word(input logic [7:0] hi, input logic [7:0] lo);
        return {hi ^ 8'hC3, lo + 8'h17};
    endfunction

    // ---------------- behavioural target ----------------
    logic [7:0] m_cmd = '0, m_ahi = '0, m_alo = '0, m_data = '0;
    int  busy_left = 0;
    logic hang = 1'b0, stuck_req = 1'b0, wr_prev = 1'b1;
    int  lat_total = 0, lat_base = 0;
    int  clk_run = 0, lat_run = 0, wr_run = 0;
    bit  busy_seen = 0, clr_busy_seen = 0;
    bit  stray_on = 0;
    int  stray_hits = 0, bus_conflicts = 0;

    assign tgt_ready = (busy_left == 0) && !hang;
    assign tgt_dq_i  = (!tgt_rd_n && m_cmd == 8'h02) ?
                       (tgt_bytesel ? flash_word(m_ahi, m_alo)[15:8] : flash_word(m_ahi, m_alo)[7:0]) : 8'h00;

    always @(posedge tgt_clk) begin
        check(tgt_dq_oe == 1'b1, "R6 bus driven at load", int'(tgt_dq_oe), 1);
        check(tgt_ready == 1'b1, "R4 no load while busy", int'(tgt_ready), 1);
        unique case (tgt_mode)
            2'b10: m_cmd = tgt_dq_o;
            2'b00: if (tgt_bytesel) m_ahi = tgt_dq_o; else m_alo = tgt_dq_o;
            2'b01: m_data = tgt_dq_o;
            default: check(1'b0, "R2 load mode code", int'(tgt_mode), 0);
        endcase
    end

    logic [31:0] exp_lat[$];
    logic [15:0] exp_rd[$];

    always @(posedge tgt_latch) begin
        lat_total++;
        if (exp_lat.size() == 0) begin
            check(1'b0, "R3 unexpected latch", lat_total, 0);
        end else begin
            logic [31:0] e;
            e = exp_lat.pop_front();
            check({m_cmd, m_ahi, m_alo, m_data} == e, "R2 R3 latched cmd/addr/data",
                  int'({m_cmd, m_ahi, m_alo, m_data}), int'(e));
        end
    end

    always @(posedge clk) begin
        wr_prev <= tgt_wr_n;
        if (!stuck_req) hang <= 1'b0;
        if (wr_prev && !tgt_wr_n) begin
            check(tgt_bytesel == 1'b0, "R4 bytesel at commit", int'(tgt_bytesel), 0);
            check(lat_total - lat_base == PAGE, "R3 latches per page", lat_total - lat_base, PAGE);
            lat_base <= lat_total;
            busy_left <= BUSY_T;
            if (stuck_req) hang <= 1'b1;
        end else if (busy_left > 0) begin
            busy_left <= busy_left - 1;
        end
        if (clr_busy_seen) busy_seen <= 0;
        else if (!tgt_ready) busy_seen <= 1;
        // pulse widths (R9)
        if (tgt_clk) clk_run <= clk_run + 1;
        else begin
            if (clk_run != 0) check(clk_run == PULSE, "R9 load clock width", clk_run, PULSE);
            clk_run <= 0;
        end
        if (tgt_latch) lat_run <= lat_run + 1;
        else begin
            if (lat_run != 0) check(lat_run == PULSE, "R9 latch width", lat_run, PULSE);
            lat_run <= 0;
        end
        if (!tgt_wr_n) wr_run <= wr_run + 1;
        else begin
            if (wr_run != 0) check(wr_run == PULSE, "R9 write pulse width", wr_run, PULSE);
            wr_run <= 0;
        end
    end

    // Monitor: read words and bus/handshake rules
    initial begin
        forever begin
            @(negedge clk);
            if (!tgt_rd_n && tgt_dq_oe) bus_conflicts++;
            if (stray_on && wr_data_ready) stray_hits++;
            if (rd_valid) begin
                check(tgt_rd_n == 1'b1, "R5 read enable restored", int'(tgt_rd_n), 1);
                if (exp_rd.size() == 0) check(1'b0, "R5 unexpected rd_valid", int'(rd_word), 0);
                else begin
                    logic [15:0] w;
                    w = exp_rd.pop_front();
                    check(rd_word == w, "R5 read word", int'(rd_word), int'(w));
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic issue_cmd(input logic op, input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr_hi = hi; cmd_addr_lo = lo;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R8 command taken", int'(cmd_ready), 0);
        check(err_timeout == 1'b0, "R7 flag cleared on accept", int'(err_timeout), 0);
    endtask

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic ee_write(input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] seed, input bit expect_ok);
        for (int i = 0; i < PAGE; i++)
            exp_lat.push_back({8'h11, hi, lo + 8'(i), seed + 8'(i * 7)});
        clr_busy_seen = 1; @(negedge clk); clr_busy_seen = 0;
        issue_cmd(1'b0, hi, lo);
        for (int i = 0; i < PAGE; i++) begin
            @(negedge clk);
            wr_data_valid = 1'b1; wr_data = seed + 8'(i * 7);
            while (!wr_data_ready) @(negedge clk);
            @(negedge clk);
            wr_data_valid = 1'b0;
        end
        wait_idle();
        if (expect_ok) begin
            check(tgt_ready == 1'b1, "R4 idle only after ready", int'(tgt_ready), 1);
            check(busy_seen, "R4 waited through busy", int'(busy_seen), 1);
            check(err_timeout == 1'b0, "R7 no error on normal write", int'(err_timeout), 0);
        end
    endtask

    task automatic fl_read(input logic [7:0] hi, input logic [7:0] lo);
        exp_rd.push_back(flash_word(hi, lo));
        issue_cmd(1'b1, hi, lo);
        wait_idle();
        check(exp_rd.size() == 0, "R5 word returned", exp_rd.size(), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
        check({tgt_rd_n, tgt_wr_n} == 2'b11, "R1 strobes idle", int'({tgt_rd_n, tgt_wr_n}), 3);
        check({tgt_clk, tgt_latch, tgt_dq_oe} == 3'b000, "R1 clock/latch/bus", int'({tgt_clk, tgt_latch, tgt_dq_oe}), 0);
        check({rd_valid, err_timeout} == 2'b00, "R1 rd_valid/err", int'({rd_valid, err_timeout}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        ee_write(8'h01, 8'h10, 8'hA0, 1);          // R2 R3 R4 basic page
        fl_read(8'h12, 8'h34);                     // R5
        fl_read(8'hFF, 8'h00);
        fl_read(8'h00, 8'hFF);
        ee_write(8'h7F, 8'hFE, 8'h3C, 1);          // R3 low-address wrap
        ee_write(8'h80, 8'h00, 8'hF1, 1);          // R4 back-to-back pages
        ee_write(8'h80, 8'h04, 8'h05, 1);

        // R8: stray byte offered during a read must not be taken
        @(negedge clk);
        wr_data_valid = 1'b1; wr_data = 8'hBD; stray_on = 1;
        fl_read(8'h5A, 8'hA5);
        @(negedge clk);
        stray_on = 0; wr_data_valid = 1'b0;
        check(stray_hits == 0, "R8 byte port quiet during read", stray_hits, 0);

        // R7: target never becomes ready
        stuck_req = 1'b1;
        ee_write(8'h22, 8'h40, 8'h90, 0);
        check(err_timeout == 1'b1, "R7 timeout flag", int'(err_timeout), 1);
        check(cmd_ready == 1'b1, "R7 back to idle", int'(cmd_ready), 1);
        stuck_req = 1'b0;
        repeat (BUSY_T + 5) @(negedge clk);
        fl_read(8'h33, 8'h44);                     // issue_cmd checks R7 clear
        check(err_timeout == 1'b0, "R7 flag stays clear", int'(err_timeout), 0);

        repeat (10) @(negedge clk);
        check(exp_lat.size() == 0, "R3 all latches seen", exp_lat.size(), 0);
        check(bus_conflicts == 0, "R6 bus released while reading", bus_conflicts, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R4 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule